// File: doc/BRIEF.md
# Sample Clipper and Converter Lane Distributor

This block sits between a transform engine and a bank of serializers that feed an interleaved high-speed digital-to-analog converter. Each clock cycle it receives a full frame of 128 real-valued, signed 10-bit time-domain samples. Only the real part of the transform output reaches this block. It maps every sample onto a 4-bit converter code and spreads the codes across sixteen parallel lane words. When the serializers shift those words out and the converter interleaves them, the samples leave in their original order.

The mapping uses a selectable clip level. A 3-bit shift selector picks how many low-order bits are rounded away. The rounding is half-up. The rounded value is saturated to the signed 4-bit range and then written in offset-binary form. A test input replaces every code with mid-scale.

The block has two register stages. The first holds the clipped codes and the second holds the packed lane words. The valid flag is delayed by the same two stages. When no valid frame arrives, both stages keep their contents.

Top module: `clip_lane_distributor`

## Requirements
- R1: A frame presented with `inValid` high at clock edge N appears on `laneData` with `outValid` high after edge N+2. Frames on consecutive cycles come out on consecutive cycles.
- R2: With effective shift s, a sample x becomes y = floor((x + 2^(s-1)) / 2^s) for s > 0, and y = x for s = 0. Ties therefore round toward positive infinity.
- R3: Any y above +7 is saturated to +7, and any y below -8 is saturated to -8. The code is then 15 or 0.
- R4: The output code is offset binary, y + 8, in the range 0 to 15. Zero maps to code 8.
- R5: `clipShift` values of 0 to 6 are used as given. The value 7 behaves exactly like 6.
- R6: Sample i, held at `sampleData[10*i +: 10]`, goes to lane i mod 16, slot i div 16. Its code sits at `laneData[32*(i mod 16) + 4*(i div 16) +: 4]`.
- R7: When `midScale` is high with a valid frame, every code in that frame is 8, whatever the sample values.
- R8: While `inValid` is low, changes on `sampleData`, `clipShift` and `midScale` have no effect. `laneData` holds its last value and `outValid` drops to 0 after the pipeline drains.
- R9: After reset, `outValid` is 0 and `laneData` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Frame on `sampleData` is valid this cycle |
| sampleData | input | 1280 | 128 signed 10-bit samples, sample i at bits 10*i+9..10*i |
| clipShift | input | 3 | Number of low bits rounded away (7 treated as 6) |
| midScale | input | 1 | Test mode: force every code of the frame to 8 |
| outValid | output | 1 | `laneData` carries a new frame |
| laneData | output | 512 | Sixteen 32-bit lane words, lane k at bits 32*k+31..32*k |

## Verification
The clocked checks assume that `clipShift` and `midScale` matter only in cycles where `inValid` is high. They also assume that a fully negative or fully positive first sample must saturate under every shift setting. The stimulus draws sample values, shifts and test-mode bits from the whole legal range. In idle cycles it deliberately drives random values onto the data and control inputs, to show they are ignored. Directed frames cover the two full-scale extremes, the out-of-range shift code, ramp patterns that make the lane placement visible, and back-to-back frames.

// File: rtl/cld_pkg.sv
package cld_pkg;
  localparam int SAMPLE_W    = 10;
  localparam int CODE_W      = 4;
  localparam int NUM_SAMPLES = 128;
  localparam int NUM_LANES   = 16;
  localparam int SHIFT_MAXV  = SAMPLE_W - CODE_W;
  localparam int SHIFT_W     = $clog2(SHIFT_MAXV + 1);

  typedef struct packed {
    logic               ld1;
    logic               ld2;
    logic               forceMid;
    logic [SHIFT_W-1:0] shiftAmt;
  } ctrlStrobes_t;
endpackage

// File: rtl/cld_ctrl.sv
module cld_ctrl
  import cld_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SHIFT_W-1:0]  clipShift,
  input  logic                midScale,
  output ctrlStrobes_t        strobes,
  output logic                outValid
);
  localparam logic [SHIFT_W-1:0] SHIFT_MAX = SHIFT_W'(SHIFT_MAXV);

  logic validStage1;
  logic validStage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validStage1 <= 1'b0;
      validStage2 <= 1'b0;
    end else begin
      validStage1 <= inValid;
      validStage2 <= validStage1;
    end
  end

  always_comb begin
    strobes.ld1      = inValid;
    strobes.ld2      = validStage1;
    strobes.forceMid = midScale;
    strobes.shiftAmt = (clipShift > SHIFT_MAX) ? SHIFT_MAX : clipShift;
  end

  assign outValid = validStage2;

  // R5: the effective shift never exceeds the usable range
  a_r5_shift_range: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftAmt <= SHIFT_MAX);
endmodule

// File: rtl/cld_datapath.sv
module cld_datapath
  import cld_pkg::*;
#(
  parameter int NUM_S = NUM_SAMPLES,
  parameter int NUM_L = NUM_LANES
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strobes,
  input  logic [NUM_S*SAMPLE_W-1:0]   sampleData,
  output logic [NUM_S*CODE_W-1:0]     laneData
);
  localparam int SLOTS  = NUM_S / NUM_L;
  localparam int LANE_W = SLOTS * CODE_W;
  localparam logic signed [SAMPLE_W:0] HALF_ONE = 1;
  localparam logic signed [SAMPLE_W:0] CODE_HI  = (2 ** (CODE_W - 1)) - 1;
  localparam logic signed [SAMPLE_W:0] CODE_LO  = -(2 ** (CODE_W - 1));
  localparam logic [CODE_W-1:0]        MID_CODE = CODE_W'(2 ** (CODE_W - 1));

  logic [NUM_S-1:0][CODE_W-1:0] nextCode;
  logic [NUM_S-1:0][CODE_W-1:0] codeReg;
  logic [NUM_S*CODE_W-1:0]      packedLanes;
  logic [NUM_S*CODE_W-1:0]      laneReg;

  for (genvar i = 0; i < NUM_S; i++) begin : g_clip
    logic signed [SAMPLE_W:0] extended;
    logic signed [SAMPLE_W:0] halfStep;
    logic signed [SAMPLE_W:0] rounded;
    logic signed [SAMPLE_W:0] clamped;
    always_comb begin
      extended = {sampleData[i*SAMPLE_W + SAMPLE_W - 1], sampleData[i*SAMPLE_W +: SAMPLE_W]};
      halfStep = '0;
      if (strobes.shiftAmt != '0) halfStep = HALF_ONE <<< (strobes.shiftAmt - 1'b1);
      rounded = (extended + halfStep) >>> strobes.shiftAmt;
      if (rounded > CODE_HI)      clamped = CODE_HI;
      else if (rounded < CODE_LO) clamped = CODE_LO;
      else                        clamped = rounded;
      if (strobes.forceMid) nextCode[i] = MID_CODE;
      else nextCode[i] = {~clamped[CODE_W-1], clamped[CODE_W-2:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            codeReg <= '0;
    else if (strobes.ld1) codeReg <= nextCode;
  end

  for (genvar k = 0; k < NUM_L; k++) begin : g_lane
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
      assign packedLanes[k*LANE_W + j*CODE_W +: CODE_W] = codeReg[j*NUM_L + k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            laneReg <= '0;
    else if (strobes.ld2) laneReg <= packedLanes;
  end

  assign laneData = laneReg;

  // R8: clipped codes keep their value without a load strobe
  a_r8_codes_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ld1 |=> $stable(codeReg));
  // R8: lane words keep their value without a load strobe
  a_r8_lanes_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ld2 |=> $stable(laneReg));
  // R7: test mode yields mid-scale codes at both ends of the frame
  a_r7_mid_scale: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ld1 && strobes.forceMid |=> codeReg[0] == MID_CODE && codeReg[NUM_S-1] == MID_CODE);
  // R3: the most negative sample saturates to code 0 at any shift
  a_r3_sat_low: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ld1 && !strobes.forceMid && sampleData[SAMPLE_W-1:0] == {1'b1, {(SAMPLE_W-1){1'b0}}}
    |=> codeReg[0] == '0);
  // R3: the most positive sample saturates to code 15 at any shift
  a_r3_sat_high: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ld1 && !strobes.forceMid && sampleData[SAMPLE_W-1:0] == {1'b0, {(SAMPLE_W-1){1'b1}}}
    |=> codeReg[0] == '1);
  // R6: sample 0 lands in the lowest slot of lane 0
  a_r6_first_slot: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ld2 |=> laneReg[CODE_W-1:0] == $past(codeReg[0]));
endmodule

// File: rtl/clip_lane_distributor.sv
module clip_lane_distributor
  import cld_pkg::*;
#(
  parameter int NUM_S = NUM_SAMPLES,
  parameter int NUM_L = NUM_LANES
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [NUM_S*SAMPLE_W-1:0]  sampleData,
  input  logic [SHIFT_W-1:0]         clipShift,
  input  logic                       midScale,
  output logic                       outValid,
  output logic [NUM_S*CODE_W-1:0]    laneData
);
  ctrlStrobes_t strobes;

  cld_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .clipShift (clipShift),
    .midScale  (midScale),
    .strobes   (strobes),
    .outValid  (outValid)
  );

  cld_datapath #(.NUM_S(NUM_S), .NUM_L(NUM_L)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .sampleData (sampleData),
    .laneData   (laneData)
  );

  // R1: a valid frame leaves two edges later
  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);
endmodule

// File: tb/clip_lane_distributor_test.sv
`timescale 1ns/1ps
module clip_lane_distributor_test;
  localparam int NS = 128;
  localparam int NL = 16;
  localparam int SW = 10;
  localparam int CW = 4;
  localparam int DW = NS * SW;
  localparam int OW = NS * CW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [DW-1:0] sampleData = '0;
  logic [2:0] clipShift = '0;
  logic midScale = 1'b0;
  logic outValid;
  logic [OW-1:0] laneData;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  clip_lane_distributor uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sampleData(sampleData),
    .clipShift(clipShift), .midScale(midScale), .outValid(outValid), .laneData(laneData)
  );

  function automatic int codeOf(input int x, input int sh, input bit mid);
    int s = (sh > 6) ? 6 : sh;
    int v = x;
    if (mid) return 8;
    if (s > 0) v = (v + (1 << (s - 1))) >>> s;
    if (v > 7) v = 7;
    if (v < -8) v = -8;
    return v + 8;
  endfunction

  function automatic logic [OW-1:0] expLanes(input logic [DW-1:0] d, input int sh, input bit mid);
    logic [OW-1:0] r = '0;
    for (int i = 0; i < NS; i++) begin
      int x = $signed(d[i*SW +: SW]);
      r[32*(i % NL) + 4*(i / NL) +: 4] = 4'(codeOf(x, sh, mid));
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] randFrame();
    logic [DW-1:0] d;
    for (int i = 0; i < NS; i++) d[i*SW +: SW] = SW'($urandom);
    return d;
  endfunction

  task automatic check1(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkLanes(input logic [OW-1:0] exp, input string tag);
    for (int k = 0; k < NL; k++)
      check1(laneData[32*k +: 32] == exp[32*k +: 32], tag,
             longint'(laneData[32*k +: 32]), longint'(exp[32*k +: 32]));
  endtask

  task automatic idleNoise();
    sampleData = randFrame();
    clipShift  = 3'($urandom);
    midScale   = 1'($urandom);
  endtask

  task automatic runOne(input logic [DW-1:0] d, input int sh, input bit mid, input string tag);
    logic [OW-1:0] exp = expLanes(d, sh, mid);
    sampleData = d; clipShift = 3'(sh); midScale = mid; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; idleNoise();
    @(negedge clk);
    check1(outValid == 1'b1, "R1 outValid after two edges", outValid, 1);
    checkLanes(exp, tag);
    idleNoise();
    @(negedge clk);
    check1(outValid == 1'b0, "R8 outValid drops when idle", outValid, 0);
    checkLanes(exp, "R8 lanes hold while idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check1(outValid == 1'b0, "R9 reset outValid", outValid, 0);
    check1(laneData == '0, "R9 reset laneData", 0, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R4: exact rounding ties at shift 1 (5 -> 3 -> code 11, -5 -> -2 -> code 6)
    d = '0;
    d[0 +: SW] = SW'(5);
    d[SW +: SW] = SW'(-5);
    runOne(d, 1, 1'b0, "R2 R4 half-up rounding ties");
    check1(laneData[32 +: 4] == 4'd6, "R2 negative tie code", laneData[32 +: 4], 6);
    check1(laneData[3:0] == 4'd11, "R4 positive tie code", laneData[3:0], 11);

    d = '0;
    runOne(d, 3, 1'b0, "R4 zero maps to code 8");
    check1(laneData[3:0] == 4'd8, "R4 zero code", laneData[3:0], 8);

    for (int i = 0; i < NS; i++) d[i*SW +: SW] = 10'h200;
    runOne(d, 6, 1'b0, "R3 full negative saturates");
    check1(laneData == '0, "R3 all codes 0", 0, 0);
    for (int i = 0; i < NS; i++) d[i*SW +: SW] = 10'h1FF;
    runOne(d, 0, 1'b0, "R3 full positive saturates");
    check1(laneData == '1, "R3 all codes 15", 0, 0);

    for (int i = 0; i < NS; i++) d[i*SW +: SW] = SW'((i % 16) - 8);
    runOne(d, 0, 1'b0, "R6 ramp by lane");
    for (int i = 0; i < NS; i++) d[i*SW +: SW] = SW'(8 * ((i / 16) - 4));
    runOne(d, 3, 1'b0, "R6 ramp by slot");

    d = randFrame();
    runOne(d, 7, 1'b0, "R5 shift 7 acts as 6");
    check1(laneData == expLanes(d, 6, 1'b0), "R5 shift 7 equals shift 6", 0, 0);

    d = randFrame();
    runOne(d, 2, 1'b1, "R7 test mode mid-scale");

    // R1: back-to-back frames
    a = randFrame(); b = randFrame();
    sampleData = a; clipShift = 3'd4; midScale = 1'b0; inValid = 1'b1;
    @(negedge clk);
    sampleData = b; clipShift = 3'd1;
    @(negedge clk);
    inValid = 1'b0; idleNoise();
    check1(outValid == 1'b1, "R1 first of pair valid", outValid, 1);
    checkLanes(expLanes(a, 4, 1'b0), "R1 first of pair");
    @(negedge clk);
    check1(outValid == 1'b1, "R1 second of pair valid", outValid, 1);
    checkLanes(expLanes(b, 1, 1'b0), "R1 second of pair");
    @(negedge clk);

    for (int t = 0; t < 40; t++) begin
      d = randFrame();
      runOne(d, int'($urandom % 8), 1'($urandom % 8 == 0), "R2 R3 R4 R6 random frame");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule